// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a memory-mapped watchdog timer for a system-on-chip. A 16-bit up-counter advances on prescaled ticks taken from one of three tick sources. All three sources arrive as single-cycle pulses that are already in the core clock domain. When the counter reaches a programmed 16-bit compare value while the watchdog is enabled, the block raises a one-cycle system reset request.

Software programs four registers. It chooses the tick source and a power-of-four prescaler, sets the compare value, and then enables counting. From then on it must keep clearing the counter, by writing zero to it, before the compare value is reached. While the watchdog is disabled, the settings can be changed freely and no timeout can happen.

The bus side is a simple synchronous register port. It has a byte address, a write strobe and 16-bit write data. Read data is combinational and depends on the address only.

Top module: `wdog_prescaled`

## Requirements
- R1: After reset the compare register reads 0xFFFF, and the enable, counter and control registers read 0. The reset request output is low.
- R2: Address bits [3:2] select the register: 0x0 is compare (16 bits), 0x4 is enable (bit 0), 0x8 is the live counter (16 bits) and 0xC is control (bits [5:0]). Read data shows the addressed register in the same cycle, and unused upper bits read as zero.
- R3: Control bits [2:0] pick the tick source one-hot. Bit 0 takes src_tick[0], bit 1 takes src_tick[1] and bit 2 takes src_tick[2]. Pulses on sources that are not selected are not counted.
- R4: When control bits [2:0] are zero, or have more than one bit set, no ticks are counted.
- R5: Control bits [5:3] hold a prescaler code c. For c from 0 to 5, the counter advances once per 4^c selected ticks.
- R6: Prescaler codes 6 and 7 divide by 1024.
- R7: Counting happens only while enable bit 0 is 1. With enable at 0, the counter and the prescaler hold their values, and no reset request is raised even when the counter equals the compare value.
- R8: Writing 0x0000 to the counter register clears both the counter and the prescaler. Writing any non-zero value to the counter register has no effect.
- R9: Any write to the control register clears the prescaler, so the next counter step takes a full prescaler period.
- R10: A prescaled tick that arrives while enabled, with the counter equal to the compare value, raises the reset request for exactly one cycle. The request starts in the cycle after the clock edge that took the tick. The counter then holds at the compare value.
- R11: After a request, further ticks raise no new request until the counter is cleared or the watchdog is disabled. After either of these, a new match raises a request again.
- R12: Each prescaled tick adds exactly one to the counter. If a zero write to the counter lands in the same cycle as a tick, the counter ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| src_tick | input | 3 | Single-cycle tick pulses from the three count sources |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Read data depends on the address alone, so it is valid in the cycle the address is driven. A register write shows up on reads from the cycle after its edge. A tick taken at an edge has changed the counter by the following cycle. The reset request goes high in the cycle after the edge that took the matching tick and drops one cycle later. The bench drives every input just after a rising edge and queues each expected value together with the cycle in which it is due. A monitor compares the queued value against the ports on the next falling edge, so every comparison falls mid-cycle, inside the one cycle in which that result is defined.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // Register select, taken from byte-address bits [3:2]
   typedef enum logic [1:0] {
      REG_CMP = 2'd0,
      REG_EN  = 2'd1,
      REG_CNT = 2'd2,
      REG_CTL = 2'd3
   } wdog_reg_e;

   localparam int unsigned WDOG_ADDR_W = 4;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned SRC_N      = 3,
   parameter int unsigned PRE_CODE_W = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [WDOG_ADDR_W-1:0]        bus_addr,
   input  logic                          bus_wr,
   input  logic [DATA_W-1:0]             bus_wdata,
   output logic [DATA_W-1:0]             bus_rdata,
   input  logic [CNT_W-1:0]              cnt_i,
   output logic [CNT_W-1:0]              cmp_o,
   output logic                          en_o,
   output logic [SRC_N-1:0]              src_sel_o,
   output logic [PRE_CODE_W-1:0]         pre_code_o,
   output logic                          cnt_clr_o,
   output logic                          pre_clr_o
);

   localparam int unsigned CTL_W = SRC_N + PRE_CODE_W;

   wdog_reg_e          reg_sel;
   logic [CNT_W-1:0]   cmp_q;
   logic               en_q;
   logic [CTL_W-1:0]   ctl_q;
   logic               wr_cmp, wr_en, wr_cnt, wr_ctl;
   logic [1:0]         unused_addr_lo;

   assign reg_sel        = wdog_reg_e'(bus_addr[3:2]);
   assign unused_addr_lo = bus_addr[1:0];

   assign wr_cmp = bus_wr && (reg_sel == REG_CMP);
   assign wr_en  = bus_wr && (reg_sel == REG_EN);
   assign wr_cnt = bus_wr && (reg_sel == REG_CNT);
   assign wr_ctl = bus_wr && (reg_sel == REG_CTL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q <= '1;
         en_q  <= 1'b0;
         ctl_q <= '0;
      end else begin
         if (wr_cmp) cmp_q <= bus_wdata[CNT_W-1:0];
         if (wr_en)  en_q  <= bus_wdata[0];
         if (wr_ctl) ctl_q <= bus_wdata[CTL_W-1:0];
      end
   end

   // Keep-alive: only an all-zero write touches the counter
   assign cnt_clr_o = wr_cnt && (bus_wdata == '0);
   assign pre_clr_o = cnt_clr_o || wr_ctl;

   assign cmp_o      = cmp_q;
   assign en_o       = en_q;
   assign src_sel_o  = ctl_q[SRC_N-1:0];
   assign pre_code_o = ctl_q[CTL_W-1:SRC_N];

   always_comb begin
      unique case (reg_sel)
         REG_CMP: bus_rdata = DATA_W'(cmp_q);
         REG_EN:  bus_rdata = DATA_W'(en_q);
         REG_CNT: bus_rdata = DATA_W'(cnt_i);
         REG_CTL: bus_rdata = DATA_W'(ctl_q);
         default: bus_rdata = '0;
      endcase
   end

   AST_EN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> (en_q == $past(bus_wdata[0]))); // R7
   AST_CTL_HELD: assert property (@(posedge clk) disable iff (!rst_n) !wr_ctl |=> $stable(ctl_q)); // R2

endmodule

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
   parameter int unsigned SRC_N        = 3,
   parameter int unsigned PRE_CODE_W   = 3,
   parameter int unsigned PRE_STEP_LOG = 2,
   parameter int unsigned PRE_MAX_CODE = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en_i,
   input  logic                  clr_i,
   input  logic [SRC_N-1:0]      src_tick_i,
   input  logic [SRC_N-1:0]      src_sel_i,
   input  logic [PRE_CODE_W-1:0] pre_code_i,
   output logic                  step_o
);

   localparam int unsigned PRE_W = PRE_STEP_LOG * PRE_MAX_CODE;

   logic sel_ok;
   logic sel_tick;

   // One-hot check without a reduction primitive
   assign sel_ok   = (src_sel_i != '0) && ((src_sel_i & (src_sel_i - SRC_N'(1))) == '0);
   assign sel_tick = sel_ok && ((src_tick_i & src_sel_i) != '0);

   generate
      if (PRE_W == 0) begin : g_no_pre
         logic [PRE_CODE_W-1:0] unused_code;
         logic                  unused_clk;
         assign unused_code = pre_code_i;
         assign unused_clk  = clk;
         assign step_o      = en_i && !clr_i && sel_tick;
      end else begin : g_pre
         logic [PRE_CODE_W-1:0] code_eff;
         logic [PRE_W:0]        span;
         logic [PRE_W-1:0]      term;
         logic [PRE_W-1:0]      pre_q;

         // Codes above the largest divider saturate at it
         assign code_eff = (pre_code_i > PRE_CODE_W'(PRE_MAX_CODE)) ?
                           PRE_CODE_W'(PRE_MAX_CODE) : pre_code_i;

         always_comb begin
            span = (PRE_W+1)'(1) << (PRE_STEP_LOG * int'(code_eff));
            term = PRE_W'(span - (PRE_W+1)'(1));
         end

         always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
               pre_q <= '0;
            end else if (en_i && sel_tick) begin
               if (pre_q == term) pre_q <= '0;
               else               pre_q <= pre_q + PRE_W'(1);
            end
         end

         assign step_o = en_i && !clr_i && sel_tick && (pre_q == term);

         AST_PRE_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!en_i && !clr_i) |=> $stable(pre_q)); // R7
         AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) clr_i |=> (pre_q == '0)); // R9
      end
   endgenerate

   AST_STEP_NEEDS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) step_o |-> ($countones(src_sel_i) == 1)); // R4
   AST_STEP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) step_o |-> en_i); // R7

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             step_i,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             req_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             fired_q;
   logic             req_q;
   logic             hit;
   logic             fire;

   assign hit  = (cnt_q == cmp_i);
   assign fire = step_i && hit && !fired_q && !clr_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
         req_q   <= 1'b0;
      end else begin
         req_q <= fire;
         if (clr_i) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
         end else begin
            if (!en_i)       fired_q <= 1'b0;
            else if (fire)   fired_q <= 1'b1;
            if (step_i && !hit) cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign cnt_o = cnt_q;
   assign req_o = req_q;

   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) req_q |=> !req_q); // R10
   AST_HOLD_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (hit && !clr_i) |=> $stable(cnt_q)); // R10
   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clr_i |=> (cnt_q == '0)); // R8
   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n) !clr_i |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)))); // R12
   AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!en_i && !clr_i) |=> ($stable(cnt_q) && !req_q)); // R7
   AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n) (req_q && !clr_i && en_i) |=> !req_q); // R11

endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned SRC_N        = 3,
   parameter int unsigned PRE_CODE_W   = 3,
   parameter int unsigned PRE_STEP_LOG = 2,
   parameter int unsigned PRE_MAX_CODE = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [WDOG_ADDR_W-1:0] bus_addr,
   input  logic                   bus_wr,
   input  logic [DATA_W-1:0]      bus_wdata,
   output logic [DATA_W-1:0]      bus_rdata,
   input  logic [SRC_N-1:0]       src_tick,
   output logic                   rst_req
);

   generate
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("counter wider than the data bus");
      end
      if (SRC_N + PRE_CODE_W > DATA_W) begin : g_bad_ctl
         $error("control field wider than the data bus");
      end
      if (PRE_MAX_CODE >= (1 << PRE_CODE_W)) begin : g_bad_code
         $error("largest prescaler code does not fit its field");
      end
      if (SRC_N == 0 || CNT_W == 0) begin : g_bad_zero
         $error("zero-width source select or counter");
      end
   endgenerate

   logic [CNT_W-1:0]      cmp;
   logic [CNT_W-1:0]      cnt;
   logic                  en;
   logic [SRC_N-1:0]      src_sel;
   logic [PRE_CODE_W-1:0] pre_code;
   logic                  cnt_clr;
   logic                  pre_clr;
   logic                  step;

   wdog_regs #(
      .DATA_W     (DATA_W),
      .CNT_W      (CNT_W),
      .SRC_N      (SRC_N),
      .PRE_CODE_W (PRE_CODE_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .cnt_i      (cnt),
      .cmp_o      (cmp),
      .en_o       (en),
      .src_sel_o  (src_sel),
      .pre_code_o (pre_code),
      .cnt_clr_o  (cnt_clr),
      .pre_clr_o  (pre_clr)
   );

   wdog_tick_gen #(
      .SRC_N        (SRC_N),
      .PRE_CODE_W   (PRE_CODE_W),
      .PRE_STEP_LOG (PRE_STEP_LOG),
      .PRE_MAX_CODE (PRE_MAX_CODE)
   ) u_tick (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en),
      .clr_i      (pre_clr),
      .src_tick_i (src_tick),
      .src_sel_i  (src_sel),
      .pre_code_i (pre_code),
      .step_o     (step)
   );

   wdog_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en),
      .step_i (step),
      .clr_i  (cnt_clr),
      .cmp_i  (cmp),
      .cnt_o  (cnt),
      .req_o  (rst_req)
   );

   AST_REQ_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> !rst_req); // R1
   AST_REQ_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> (cnt == $past(cmp))); // R10

endmodule

// File: tb/wdog_prescaled_tb.sv
`timescale 1ns/1ps
module wdog_prescaled_tb;

   typedef struct {
      int          kind;   // 0: read data, 1: reset request
      logic [15:0] exp;
      string       tag;
   } sb_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [2:0]  src_tick = '0;
   logic        rst_req;

   sb_item_t    sb_q[$];
   sb_item_t    cur;
   logic [15:0] got;
   int          n_chk = 0;
   int          n_err = 0;
   int          n_cyc = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   wdog_prescaled u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .src_tick  (src_tick),
      .rst_req   (rst_req)
   );

   // Monitor: pops every item due this cycle, compares mid-cycle
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         cur = sb_q.pop_front();
         got = (cur.kind == 0) ? bus_rdata : {15'd0, rst_req};
         n_chk++;
         if (got !== cur.exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", cur.tag, got, cur.exp);
         end
      end
   end

   always @(posedge clk) begin
      n_cyc++;
      if (n_cyc == 150000 && !done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got %0d cycles expected completion", n_cyc);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      cyc();
      bus_wr    = 1'b0;
   endtask

   task automatic ticks(input logic [2:0] m, input int n);
      for (int i = 0; i < n; i++) begin
         src_tick = m;
         cyc();
         src_tick = '0;
      end
   endtask

   task automatic exp_rd(input logic [3:0] a, input logic [15:0] e, input string tag);
      sb_item_t it;
      bus_addr = a;
      it.kind = 0; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      #1;
   endtask

   task automatic exp_req(input logic e, input string tag);
      sb_item_t it;
      it.kind = 1; it.exp = {15'd0, e}; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      #1;
   endtask

   initial begin
      repeat (5) cyc();
      rst_n = 1'b1;
      cyc();

      // R1 reset values
      exp_rd(4'h0, 16'hFFFF, "R1 compare");
      exp_rd(4'h4, 16'h0000, "R1 enable");
      exp_rd(4'h8, 16'h0000, "R1 counter");
      exp_rd(4'hC, 16'h0000, "R1 control");
      exp_req(1'b0, "R1 request");

      // R2 readback and unused bits
      wr(4'hC, 16'hFFFF);  exp_rd(4'hC, 16'h003F, "R2 control width");
      wr(4'h0, 16'h1234);  exp_rd(4'h0, 16'h1234, "R2 compare");
      wr(4'h4, 16'hFFFE);  exp_rd(4'h4, 16'h0000, "R2 enable bit0 low");
      wr(4'h4, 16'h0003);  exp_rd(4'h4, 16'h0001, "R2 enable bit0 high");
      wr(4'h4, 16'h0000);

      // R3 source selection, divide by 1
      wr(4'hC, 16'h0002); wr(4'h0, 16'hFFFF); wr(4'h8, 16'h0000); wr(4'h4, 16'h0001);
      ticks(3'b001, 3);   exp_rd(4'h8, 16'd0, "R3 unselected source");
      ticks(3'b010, 3);   exp_rd(4'h8, 16'd3, "R3 second source");
      ticks(3'b100, 2);   exp_rd(4'h8, 16'd3, "R3 third source unselected");
      wr(4'hC, 16'h0004);
      ticks(3'b100, 2);   exp_rd(4'h8, 16'd5, "R3 third source");

      // R4 invalid selections
      wr(4'hC, 16'h0003);
      ticks(3'b111, 4);   exp_rd(4'h8, 16'd5, "R4 two bits set");
      wr(4'hC, 16'h0000);
      ticks(3'b111, 4);   exp_rd(4'h8, 16'd5, "R4 no bit set");

      // R5 prescaler codes 1 and 2
      wr(4'hC, 16'h0009); wr(4'h8, 16'h0000);
      ticks(3'b001, 3);   exp_rd(4'h8, 16'd0, "R5 div4 partial");
      ticks(3'b001, 1);   exp_rd(4'h8, 16'd1, "R5 div4 step");
      ticks(3'b001, 4);   exp_rd(4'h8, 16'd2, "R5 div4 second step");
      wr(4'hC, 16'h0011); wr(4'h8, 16'h0000);
      ticks(3'b001, 15);  exp_rd(4'h8, 16'd0, "R5 div16 partial");
      ticks(3'b001, 1);   exp_rd(4'h8, 16'd1, "R5 div16 step");

      // R6 codes 6 and 7 saturate at 1024
      wr(4'hC, 16'h0031); wr(4'h8, 16'h0000);
      ticks(3'b001, 1023); exp_rd(4'h8, 16'd0, "R6 code6 partial");
      ticks(3'b001, 1);    exp_rd(4'h8, 16'd1, "R6 code6 step");
      wr(4'hC, 16'h0039); wr(4'h8, 16'h0000);
      ticks(3'b001, 1023); exp_rd(4'h8, 16'd0, "R6 code7 partial");
      ticks(3'b001, 1);    exp_rd(4'h8, 16'd1, "R6 code7 step");

      // R9 control write clears prescaler
      wr(4'hC, 16'h0009); wr(4'h8, 16'h0000);
      ticks(3'b001, 2);
      wr(4'hC, 16'h0009);
      ticks(3'b001, 3);   exp_rd(4'h8, 16'd0, "R9 full period after control write");
      ticks(3'b001, 1);   exp_rd(4'h8, 16'd1, "R9 step after full period");

      // R8 keep-alive and ignored non-zero write
      wr(4'h8, 16'h0005); exp_rd(4'h8, 16'd1, "R8 non-zero write ignored");
      ticks(3'b001, 2);
      wr(4'h8, 16'h0000); exp_rd(4'h8, 16'd0, "R8 zero write clears");
      ticks(3'b001, 3);   exp_rd(4'h8, 16'd0, "R8 prescaler cleared");
      ticks(3'b001, 1);   exp_rd(4'h8, 16'd1, "R8 step after ping");

      // R12 clear wins over a simultaneous tick
      wr(4'hC, 16'h0001);
      ticks(3'b001, 1);   exp_rd(4'h8, 16'd2, "R12 single increment");
      bus_addr = 4'h8; bus_wdata = 16'h0000; bus_wr = 1'b1; src_tick = 3'b001;
      cyc();
      bus_wr = 1'b0; src_tick = '0;
      exp_rd(4'h8, 16'd0, "R12 clear beats tick");
      ticks(3'b001, 1);   exp_rd(4'h8, 16'd1, "R12 count resumes");

      // R7 disabled: frozen and no timeout at match
      wr(4'h4, 16'h0000);
      ticks(3'b001, 5);   exp_rd(4'h8, 16'd1, "R7 counter held");
      wr(4'h0, 16'h0001);
      for (int i = 0; i < 3; i++) begin
         ticks(3'b001, 1); exp_req(1'b0, "R7 no request while off");
      end
      wr(4'hC, 16'h0002); exp_rd(4'hC, 16'h0002, "R7 control rewritten while off");
      wr(4'hC, 16'h0001);
      wr(4'h4, 16'h0001);
      ticks(3'b001, 1);   exp_req(1'b1, "R11 fires after re-enable");
      cyc();              exp_req(1'b0, "R10 request one cycle");

      // R10 expiry
      wr(4'h0, 16'h0003); wr(4'h8, 16'h0000);
      ticks(3'b001, 3);   exp_req(1'b0, "R10 before match");
      exp_rd(4'h8, 16'd3, "R10 counter reaches compare");
      ticks(3'b001, 1);   exp_req(1'b1, "R10 request on match tick");
      cyc();              exp_req(1'b0, "R10 request drops");
      exp_rd(4'h8, 16'd3, "R10 counter holds");

      // R11 no re-fire, re-arm after clear
      for (int i = 0; i < 5; i++) begin
         ticks(3'b001, 1); exp_req(1'b0, "R11 no repeat");
      end
      exp_rd(4'h8, 16'd3, "R11 counter still held");
      wr(4'h8, 16'h0000);
      ticks(3'b001, 3);
      ticks(3'b001, 1);   exp_req(1'b1, "R11 fires after ping");
      cyc();              exp_req(1'b0, "R11 drops again");

      done = 1'b1;
      cyc();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule